// File: doc/BRIEF.md
# Frequency Synthesizer Retune Sequencer

This block steps one frequency-synthesis loop safely from one setting to another. A request carries three ratio values: the reference divider, the feedback multiplier and the post divider. In idle the sequencer checks that the request gives a legal oscillator frequency and a legal output frequency. If it does, the output is first bypassed to the 24 MHz reference. The loop is then held in reset while the new divider fields are loaded, released after a timed hold, and watched on its lock input. The loop returns to normal operation only once lock is seen.

Illegal requests, and retunes that never lock within a bounded window, end with a one-cycle error pulse. A park request puts the output into a low-power deep mode without touching the dividers. The block also reports at all times the output rate in hertz that its current mode and fields produce. The analog loop is not part of the block: its lock indication arrives on an input.

Top module: `pll_retune_seq`

## Requirements
- R1: After reset the mode select is slow (encoding 0), loop reset is low, busy, done and error are low, every divider field is 0 and the reported rate is 24000000.
- R2: A non-park request is rejected if any of these holds: NR is 0 or above 64; NF is 0 or above 8192; NO is 0, above 16, or odd and not 1; 24 MHz*NF/NR lies outside 440..2200 MHz; that frequency divided by NO lies outside 27.5..2200 MHz. A rejection gives error high for one cycle, in the cycle after the request, and leaves the mode, the fields and busy unchanged.
- R3: In the cycle after a legal request is accepted, busy is high and the mode select is slow, while the divider fields still hold their old values. Busy implies slow mode.
- R4: One cycle after loop reset rises, the fields hold NR-1 (6 bits), NF-1 (13 bits), NO-1 (4 bits) and bandwidth adjust NF/2-1 (12 bits). The fields change only while loop reset is high.
- R5: Loop reset stays high for HOLD_US*CLK_MHZ+1 cycles (101 with defaults), with the fields stable during that time.
- R6: After reset is released the block stays in slow mode with busy high until lock is high. In the cycle after lock is seen, the mode is normal (encoding 1), done is high for one cycle and busy is low. Lock is ignored while loop reset is high.
- R7: If lock stays low for LOCK_TMO cycles after reset release, error pulses LOCK_TMO cycles after the first cycle with reset low, busy falls and the mode stays slow.
- R8: Requests that arrive while busy are ignored: the fields keep the values of the accepted request.
- R9: The rate output is 24000000 in slow mode, 24000000*NF/(NR*NO) truncated in normal mode, and 32768 in deep mode (encoding 2).
- R10: A park request in idle sets the mode to deep and pulses done in the next cycle without changing any divider field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Request strobe, sampled in idle |
| req_park | input | 1 | Request is a park into deep mode |
| req_nr | input | 7 | Requested reference divider value |
| req_nf | input | 14 | Requested feedback multiplier value |
| req_no | input | 5 | Requested post divider value |
| lock_in | input | 1 | Lock indication from the loop |
| pll_rst | output | 1 | Loop reset |
| cfg_nr | output | 6 | Reference divider field (value minus one) |
| cfg_nf | output | 13 | Feedback multiplier field (value minus one) |
| cfg_no | output | 4 | Post divider field (value minus one) |
| cfg_bw | output | 12 | Bandwidth adjust field |
| mode_sel | output | 2 | Output mode: 0 slow, 1 normal, 2 deep |
| busy | output | 1 | Retune in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection or timeout pulse |
| rate_hz | output | 32 | Output rate implied by mode and fields |

## Verification
A request strobed before a clock edge shows its effect after that edge: busy and slow mode, or an error or park result, one cycle later. Loop reset rises one cycle after that, the fields are loaded one cycle after reset rises, and reset falls HOLD_US*CLK_MHZ cycles after the load. Done and normal mode follow lock by one cycle, and the timeout error comes LOCK_TMO cycles after the first cycle with reset low. The bench drives on the falling edge, samples on the next falling edge, and counts those edges explicitly, so each check lands in the exact cycle its requirement names.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [1:0] {
    MODE_SLOW   = 2'd0,
    MODE_NORMAL = 2'd1,
    MODE_DEEP   = 2'd2
  } pll_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RST   = 3'd1,
    ST_WRITE = 3'd2,
    ST_HOLD  = 3'd3,
    ST_LOCK  = 3'd4
  } seq_state_e;

endpackage

// File: rtl/pll_seq_rst_sync.sv
module pll_seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/pll_req_check.sv
module pll_req_check #(
  parameter int NR_W        = 6,
  parameter int NF_W        = 13,
  parameter int NO_W        = 4,
  parameter int REF_KHZ     = 24000,
  parameter int VCO_MIN_KHZ = 440000,
  parameter int VCO_MAX_KHZ = 2200000,
  parameter int OUT_MIN_KHZ = 27500,
  parameter int OUT_MAX_KHZ = 2200000
) (
  input  logic [NR_W:0] nr,
  input  logic [NF_W:0] nf,
  input  logic [NO_W:0] no,
  output logic          legal
);

  localparam logic [63:0] K_REF  = 64'(REF_KHZ);
  localparam logic [63:0] K_VMIN = 64'(VCO_MIN_KHZ);
  localparam logic [63:0] K_VMAX = 64'(VCO_MAX_KHZ);
  localparam logic [63:0] K_OMIN = 64'(OUT_MIN_KHZ);
  localparam logic [63:0] K_OMAX = 64'(OUT_MAX_KHZ);
  localparam logic [NR_W:0] NR_LIM = {1'b1, {NR_W{1'b0}}};
  localparam logic [NF_W:0] NF_LIM = {1'b1, {NF_W{1'b0}}};
  localparam logic [NO_W:0] NO_LIM = {1'b1, {NO_W{1'b0}}};

  logic [63:0] vco_x_nr, nr_w, nrno_w;
  logic        range_ok, no_ok, vco_ok, out_ok;

  // Compare VCO*NR and output*NR*NO against the limits, so no divider is needed.
  assign nr_w     = 64'(nr);
  assign nrno_w   = 64'(nr) * 64'(no);
  assign vco_x_nr = K_REF * 64'(nf);

  assign range_ok = (nr != '0) && (nr <= NR_LIM) && (nf != '0) && (nf <= NF_LIM) &&
                    (no != '0) && (no <= NO_LIM);
  assign no_ok    = (no == (NO_W+1)'(1)) || !no[0];
  assign vco_ok   = (vco_x_nr >= K_VMIN * nr_w) && (vco_x_nr <= K_VMAX * nr_w);
  assign out_ok   = (vco_x_nr >= K_OMIN * nrno_w) && (vco_x_nr <= K_OMAX * nrno_w);
  assign legal    = range_ok && no_ok && vco_ok && out_ok;

endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
  import pll_seq_pkg::*;
#(
  parameter int NR_W    = 6,
  parameter int NF_W    = 13,
  parameter int NO_W    = 4,
  parameter int REF_HZ  = 24000000,
  parameter int DEEP_HZ = 32768
) (
  input  pll_mode_e       mode,
  input  logic [NR_W-1:0] nr_m1,
  input  logic [NF_W-1:0] nf_m1,
  input  logic [NO_W-1:0] no_m1,
  output logic [31:0]     rate_hz
);

  logic [63:0] num, den;

  assign num = 64'(REF_HZ) * (64'(nf_m1) + 64'd1);
  assign den = (64'(nr_m1) + 64'd1) * (64'(no_m1) + 64'd1);

  always_comb begin
    case (mode)
      MODE_SLOW:   rate_hz = 32'(REF_HZ);
      MODE_NORMAL: rate_hz = 32'(num / den);
      default:     rate_hz = 32'(DEEP_HZ);
    endcase
  end

endmodule

// File: rtl/pll_seq_counter.sv
module pll_seq_counter #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
  import pll_seq_pkg::*;
#(
  parameter int REF_HZ      = 24000000,
  parameter int DEEP_HZ     = 32768,
  parameter int CLK_MHZ     = 10,
  parameter int HOLD_US     = 10,
  parameter int LOCK_TMO    = 300,
  parameter int NR_W        = 6,
  parameter int NF_W        = 13,
  parameter int NO_W        = 4,
  parameter int BW_W        = 12,
  parameter int VCO_MIN_KHZ = 440000,
  parameter int VCO_MAX_KHZ = 2200000,
  parameter int OUT_MIN_KHZ = 27500,
  parameter int OUT_MAX_KHZ = 2200000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_start,
  input  logic            req_park,
  input  logic [NR_W:0]   req_nr,
  input  logic [NF_W:0]   req_nf,
  input  logic [NO_W:0]   req_no,
  input  logic            lock_in,
  output logic            pll_rst,
  output logic [NR_W-1:0] cfg_nr,
  output logic [NF_W-1:0] cfg_nf,
  output logic [NO_W-1:0] cfg_no,
  output logic [BW_W-1:0] cfg_bw,
  output logic [1:0]      mode_sel,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic [31:0]     rate_hz
);

  localparam int HOLD_CYC = HOLD_US * CLK_MHZ;
  localparam int CNT_MAX  = (HOLD_CYC > LOCK_TMO) ? HOLD_CYC : LOCK_TMO;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam int REF_KHZ  = REF_HZ / 1000;

  logic       rst_i_n;
  seq_state_e st_q, st_d;
  pll_mode_e  mode_q, mode_d;
  logic       prst_q, prst_d, busy_q, busy_d, done_q, done_d, err_q, err_d;
  logic       lat_en, wr_en, cnt_clr, cnt_en, req_ok, hold_end, tmo_end;
  logic [CNT_W-1:0] cnt;

  logic [NR_W:0]   lat_nr_q;
  logic [NF_W:0]   lat_nf_q;
  logic [NO_W:0]   lat_no_q;
  logic [NR_W-1:0] nr_q;
  logic [NF_W-1:0] nf_q;
  logic [NO_W-1:0] no_q;
  logic [BW_W-1:0] bw_q;

  pll_seq_rst_sync u_rsync (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  pll_req_check #(
    .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .REF_KHZ(REF_KHZ),
    .VCO_MIN_KHZ(VCO_MIN_KHZ), .VCO_MAX_KHZ(VCO_MAX_KHZ),
    .OUT_MIN_KHZ(OUT_MIN_KHZ), .OUT_MAX_KHZ(OUT_MAX_KHZ)
  ) u_chkreq (.nr(req_nr), .nf(req_nf), .no(req_no), .legal(req_ok));

  pll_seq_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_i_n), .clr(cnt_clr), .en(cnt_en), .cnt(cnt)
  );

  pll_rate_calc #(
    .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .REF_HZ(REF_HZ), .DEEP_HZ(DEEP_HZ)
  ) u_rate (.mode(mode_q), .nr_m1(nr_q), .nf_m1(nf_q), .no_m1(no_q), .rate_hz(rate_hz));

  assign hold_end = (cnt == CNT_W'(HOLD_CYC - 1));
  assign tmo_end  = (cnt == CNT_W'(LOCK_TMO - 1));
  assign lat_en   = (st_q == ST_IDLE) && req_start && !req_park && req_ok;
  assign wr_en    = (st_q == ST_WRITE);

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    mode_d  = mode_q;
    prst_d  = prst_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    cnt_clr = 1'b0;
    cnt_en  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_start) begin
          if (req_park) begin
            mode_d = MODE_DEEP;
            done_d = 1'b1;
          end else if (req_ok) begin
            mode_d = MODE_SLOW;
            busy_d = 1'b1;
            st_d   = ST_RST;
          end else begin
            err_d  = 1'b1;
          end
        end
      end
      ST_RST: begin
        prst_d = 1'b1;
        st_d   = ST_WRITE;
      end
      ST_WRITE: begin
        cnt_clr = 1'b1;
        st_d    = ST_HOLD;
      end
      ST_HOLD: begin
        if (hold_end) begin
          prst_d  = 1'b0;
          cnt_clr = 1'b1;
          st_d    = ST_LOCK;
        end else begin
          cnt_en  = 1'b1;
        end
      end
      ST_LOCK: begin
        if (lock_in) begin
          mode_d = MODE_NORMAL;
          done_d = 1'b1;
          busy_d = 1'b0;
          st_d   = ST_IDLE;
        end else if (tmo_end) begin
          err_d  = 1'b1;
          busy_d = 1'b0;
          st_d   = ST_IDLE;
        end else begin
          cnt_en = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= ST_IDLE;
      mode_q <= MODE_SLOW;
      prst_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      prst_q <= prst_d;
      busy_q <= busy_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  // Request latch, enabled on acceptance
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      lat_nr_q <= '0;
      lat_nf_q <= '0;
      lat_no_q <= '0;
    end else if (lat_en) begin
      lat_nr_q <= req_nr;
      lat_nf_q <= req_nf;
      lat_no_q <= req_no;
    end
  end

  // Divider fields, loaded while the loop is held in reset
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      nr_q <= '0;
      nf_q <= '0;
      no_q <= '0;
      bw_q <= '0;
    end else if (wr_en) begin
      nr_q <= NR_W'(lat_nr_q - 1'b1);
      nf_q <= NF_W'(lat_nf_q - 1'b1);
      no_q <= NO_W'(lat_no_q - 1'b1);
      bw_q <= BW_W'((lat_nf_q >> 1) - 1'b1);
    end
  end

  assign pll_rst  = prst_q;
  assign cfg_nr   = nr_q;
  assign cfg_nf   = nf_q;
  assign cfg_no   = no_q;
  assign cfg_bw   = bw_q;
  assign mode_sel = mode_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign err      = err_q;

endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk #(
  parameter int HOLD_CYC = 100,
  parameter int NR_W     = 6,
  parameter int NF_W     = 13,
  parameter int NO_W     = 4,
  parameter int BW_W     = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pll_rst,
  input logic            lock_in,
  input logic            busy,
  input logic            done,
  input logic            err,
  input logic [1:0]      mode_sel,
  input logic [NR_W-1:0] cfg_nr,
  input logic [NF_W-1:0] cfg_nf,
  input logic [NO_W-1:0] cfg_no,
  input logic [BW_W-1:0] cfg_bw
);

  logic [31:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_cnt <= '0;
    else if (pll_rst) hi_cnt <= hi_cnt + 32'd1;
    else              hi_cnt <= '0;
  end

  // R3
  busy_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mode_sel == 2'd0));

  // R4
  field_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({cfg_nr, cfg_nf, cfg_no, cfg_bw}) |-> pll_rst);

  // R5
  hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_rst) |-> (hi_cnt == 32'(HOLD_CYC + 1)));

  // R6
  normal_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_sel == 2'd1) && ($past(mode_sel) != 2'd1)) |-> ($past(lock_in) && !$past(pll_rst)));

  // R6
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> (!busy && !(done && err)));

endmodule

bind pll_retune_seq pll_seq_chk #(
  .HOLD_CYC(HOLD_CYC), .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .BW_W(BW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pll_rst(pll_rst), .lock_in(lock_in), .busy(busy),
  .done(done), .err(err), .mode_sel(mode_sel), .cfg_nr(cfg_nr), .cfg_nf(cfg_nf),
  .cfg_no(cfg_no), .cfg_bw(cfg_bw)
);

// File: tb/sim_pll_retune_seq.sv
module sim_pll_retune_seq;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ    = 10;
  localparam int HOLD_US    = 10;
  localparam int HOLD_CYC   = HOLD_US * CLK_MHZ;
  localparam int LOCK_TMO   = 300;
  localparam int LOCK_DLY   = 20;
  localparam longint REF    = 24000000;
  localparam int NV         = 14;

  localparam int V_NR [NV] = '{1, 2, 1, 1, 1, 1, 1, 6, 12, 0, 65, 1, 9, 1};
  localparam int V_NF [NV] = '{75, 200, 50, 25, 18, 20, 19, 110, 1100, 50, 2000, 50, 400, 92};
  localparam int V_NO [NV] = '{1, 2, 2, 3, 1, 16, 16, 16, 1, 1, 2, 0, 2, 1};
  localparam bit V_OK [NV] = '{1, 0, 1, 0, 0, 1, 1, 1, 1, 0, 0, 0, 1, 0};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_start, req_park, lock_in;
  logic [6:0]  req_nr;
  logic [13:0] req_nf;
  logic [4:0]  req_no;
  logic        pll_rst, busy, done, err;
  logic [5:0]  cfg_nr;
  logic [12:0] cfg_nf;
  logic [3:0]  cfg_no;
  logic [11:0] cfg_bw;
  logic [1:0]  mode_sel;
  logic [31:0] rate_hz;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  longint e_nr = 0, e_nf = 0, e_no = 0, e_bw = 0, e_mode = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_retune_seq #(.CLK_MHZ(CLK_MHZ), .HOLD_US(HOLD_US), .LOCK_TMO(LOCK_TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_park(req_park),
    .req_nr(req_nr), .req_nf(req_nf), .req_no(req_no), .lock_in(lock_in),
    .pll_rst(pll_rst), .cfg_nr(cfg_nr), .cfg_nf(cfg_nf), .cfg_no(cfg_no),
    .cfg_bw(cfg_bw), .mode_sel(mode_sel), .busy(busy), .done(done), .err(err),
    .rate_hz(rate_hz)
  );

  task automatic chk(string rq, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic chk_fields(string rq);
    chk({rq, " nr field"}, longint'(cfg_nr), e_nr);
    chk({rq, " nf field"}, longint'(cfg_nf), e_nf);
    chk({rq, " no field"}, longint'(cfg_no), e_no);
    chk({rq, " bw field"}, longint'(cfg_bw), e_bw);
  endtask

  function automatic longint rate_of(longint m);
    if (m == 0) return REF;
    if (m == 2) return 32768;
    return (REF * (e_nf + 1)) / ((e_nr + 1) * (e_no + 1));
  endfunction

  // Drive a request for one cycle; returns at the sample after the accepting edge.
  task automatic issue(int nr, int nf, int no, bit park);
    req_nr    = 7'(nr);
    req_nf    = 14'(nf);
    req_no    = 5'(no);
    req_park  = park;
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    req_park  = 1'b0;
  endtask

  task automatic rejected(int nr, int nf, int no);
    issue(nr, nf, no, 1'b0);
    chk("R2 err pulse", longint'(err), 1);
    chk("R2 busy", longint'(busy), 0);
    chk("R2 mode kept", longint'(mode_sel), e_mode);
    chk_fields("R2");
    @(negedge clk);
    chk("R2 err single", longint'(err), 0);
  endtask

  task automatic retune(int nr, int nf, int no, bit give_lock, bit meddle);
    int hi;
    issue(nr, nf, no, 1'b0);
    chk("R3 busy", longint'(busy), 1);
    chk("R3 slow first", longint'(mode_sel), 0);
    chk_fields("R3 old");
    @(negedge clk);
    chk("R5 reset rise", longint'(pll_rst), 1);
    @(negedge clk);
    e_nr = nr - 1; e_nf = nf - 1; e_no = no - 1; e_bw = nf / 2 - 1;
    chk_fields("R4 loaded");
    hi = 2;
    if (meddle) begin
      req_nr = 7'd12; req_nf = 14'd1100; req_no = 5'd1;
      req_park = 1'b1; req_start = 1'b1; lock_in = 1'b1;
      @(negedge clk);
      if (pll_rst) hi++;
      req_start = 1'b0; req_park = 1'b0;
      @(negedge clk);
      if (pll_rst) hi++;
      lock_in = 1'b0;
    end
    for (int k = 0; k < 5000 && pll_rst; k++) begin
      @(negedge clk);
      if (pll_rst) hi++;
    end
    chk("R5 hold length", hi, HOLD_CYC + 1);
    chk_fields(meddle ? "R8 ignored" : "R5 stable");
    chk(meddle ? "R6 early lock ignored" : "R6 wait mode", longint'(mode_sel), 0);
    if (give_lock) begin
      repeat (LOCK_DLY) @(negedge clk);
      chk("R6 still waiting", longint'(busy), 1);
      lock_in = 1'b1;
      @(negedge clk);
      e_mode = 1;
      chk("R6 normal", longint'(mode_sel), 1);
      chk("R6 done", longint'(done), 1);
      chk("R6 busy low", longint'(busy), 0);
      chk("R9 normal rate", longint'(rate_hz), rate_of(1));
      @(negedge clk);
      chk("R6 done single", longint'(done), 0);
      lock_in = 1'b0;
    end else begin
      repeat (LOCK_TMO - 1) @(negedge clk);
      chk("R7 no early err", longint'(err), 0);
      @(negedge clk);
      e_mode = 0;
      chk("R7 timeout err", longint'(err), 1);
      chk("R7 busy low", longint'(busy), 0);
      chk("R7 mode slow", longint'(mode_sel), 0);
      chk("R9 slow rate", longint'(rate_hz), REF);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_start = 1'b0; req_park = 1'b0; lock_in = 1'b0;
    req_nr = '0; req_nf = '0; req_no = '0;
    repeat (3) @(negedge clk);
    chk("R1 mode in reset", longint'(mode_sel), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 mode", longint'(mode_sel), 0);
    chk("R1 pll_rst", longint'(pll_rst), 0);
    chk("R1 busy", longint'(busy), 0);
    chk("R1 done", longint'(done), 0);
    chk("R1 err", longint'(err), 0);
    chk("R1 rate", longint'(rate_hz), REF);
    chk_fields("R1");

    for (int v = 0; v < NV; v++) begin
      if (V_OK[v]) retune(V_NR[v], V_NF[v], V_NO[v], 1'b1, 1'b0);
      else         rejected(V_NR[v], V_NF[v], V_NO[v]);
      @(negedge clk);
    end

    // R10: park into deep mode keeps the fields
    issue(0, 0, 0, 1'b1);
    e_mode = 2;
    chk("R10 deep mode", longint'(mode_sel), 2);
    chk("R10 done", longint'(done), 1);
    chk("R9 deep rate", longint'(rate_hz), 32768);
    chk_fields("R10");
    @(negedge clk);

    // R2: rejection while parked leaves deep mode alone
    rejected(1, 100, 1);

    // R8 and R6: requests and early lock during the hold are ignored
    retune(1, 50, 2, 1'b1, 1'b1);
    @(negedge clk);

    // R7: no lock at all
    retune(2, 100, 2, 1'b0, 1'b0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule